// File: doc/BRIEF.md
# Scalar Register Busy-Bit Scoreboard

This block keeps one busy flag per physical scalar register of a compute unit and answers, every cycle, whether an instruction may issue. An issue query presents up to two source operands and one destination operand; each operand is a base register index plus a width flag, so it covers either one register or the base and the one above it. Issue is refused when a source overlaps a busy register (a read-after-write hazard) or, if all sources are clear, when the destination overlaps a busy register (a write-after-any hazard). Each cause has its own counter.

A mark port sets the destination registers busy when a write is scheduled. An execute port starts the release of an arithmetic result's registers, which free a fixed pipeline latency later. Loads, atomics and memory-syncs are not released there. Their registers free through a separate return port, one cycle after data comes back. A register-read and a register-write counter track operand traffic. Each register holds its own release down-counter. A later mark cancels a pending release, and a mark beats an expiring release in the same cycle.

Top module: `sreg_scoreboard`

## Requirements
- R1: When any register covered by a valid source operand is busy, `issue_ok` is low, and a valid query (`chk_valid` high) increments `raw_stalls` by one at the next clock edge.
- R2: When no source register is busy but a register covered by the valid destination operand is busy, `issue_ok` is low, and a valid query increments `wax_stalls` by one.
- R3: A query raises at most one stall counter by one. A query with `chk_valid` low, or one that finds `issue_ok` high, changes neither counter.
- R4: A mark (`mark_en` high at a clock edge) makes every covered register busy from that edge on. Width flag 0 covers only the base. Width flag 1 covers the base and base+1. Invalid operands (valid bit 0) cover nothing, and a covered index at or above NUM_REGS is ignored, with no wrap to register 0.
- R5: An execute with class code 0 (arithmetic) and a valid destination clears the busy bits of the covered registers exactly PIPE_LEN clock edges after the edge that samples it: the registers are still busy after edge PIPE_LEN-1 and free after edge PIPE_LEN.
- R6: An execute with class code 1 (load), 2 (atomic) or 3 (memory-sync) never frees its destination registers.
- R7: A return (`ret_en` high) frees the covered registers at the second clock edge. The registers are still busy after the edge that samples the return and free after the next edge.
- R8: `reg_reads` increases by `exec_src_dw` on every execute, whatever its class.
- R9: `reg_writes` increases by the destination register count (1 or 2) on an arithmetic execute with a valid destination and on every return. Other execute classes do not change it.
- R10: A mark of a register with a release pending cancels that release, and the register stays busy.
- R11: When a mark and an expiring release hit the same register at the same edge, the register stays busy and no release remains pending.
- R12: Reset (`rst_n` low) clears all busy bits, pending releases and the four counters. `issue_ok` follows the current busy state combinationally, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chk_valid | input | 1 | Issue query is real and may count a stall |
| chk_s0_vld | input | 1 | Source 0 present |
| chk_s0_base | input | IDX_W | Source 0 base index |
| chk_s0_wide | input | 1 | Source 0 covers two registers |
| chk_s1_vld | input | 1 | Source 1 present |
| chk_s1_base | input | IDX_W | Source 1 base index |
| chk_s1_wide | input | 1 | Source 1 covers two registers |
| chk_d_vld | input | 1 | Destination present |
| chk_d_base | input | IDX_W | Destination base index |
| chk_d_wide | input | 1 | Destination covers two registers |
| issue_ok | output | 1 | No hazard on the queried operands |
| mark_en | input | 1 | Schedule a write: set registers busy |
| mark_base | input | IDX_W | Mark base index |
| mark_wide | input | 1 | Mark covers two registers |
| exec_en | input | 1 | Instruction executes this cycle |
| exec_cls | input | 2 | Class: 0 arithmetic, 1 load, 2 atomic, 3 memory-sync |
| exec_src_dw | input | 3 | Source dwords read by this instruction |
| exec_d_vld | input | 1 | Executing instruction has a destination |
| exec_d_base | input | IDX_W | Execute destination base index |
| exec_d_wide | input | 1 | Execute destination covers two registers |
| ret_en | input | 1 | Load or atomic data returned |
| ret_base | input | IDX_W | Return destination base index |
| ret_wide | input | 1 | Return destination covers two registers |
| raw_stalls | output | CNT_W | Read-after-write stall count |
| wax_stalls | output | CNT_W | Write-after-any stall count |
| reg_reads | output | CNT_W | Register dwords read |
| reg_writes | output | CNT_W | Register dwords written |

## Verification
The bench builds the block with NUM_REGS = 16, PIPE_LEN = 4 and CNT_W = 16. Sixteen registers put the top index 15 within easy reach, so a two-register operand based there tests the out-of-range rule and shows that no wrap reaches register 0. A four-cycle latency is short enough to probe the register at both edge PIPE_LEN-1 and edge PIPE_LEN, and to place a re-mark or a colliding mark inside a pending release window.

// File: rtl/sreg_sb_pkg.sv
// Package: shared types and helpers for the scalar register scoreboard.
// Assumes an operand covers one register, or two when its width flag is set.
package sreg_sb_pkg;

    typedef enum logic [1:0] {
        CLS_ALU    = 2'd0,
        CLS_LOAD   = 2'd1,
        CLS_ATOMIC = 2'd2,
        CLS_MSYNC  = 2'd3
    } exec_cls_e;

    // Number of dwords an operand of the given width covers.
    function automatic logic [1:0] span_dwords(input logic wide);
        return wide ? 2'd2 : 2'd1;
    endfunction

endpackage

// File: rtl/sreg_span_decode.sv
// Module: turns one operand (valid, base, width flag) into a one-hot-or-two
// mask over the register file. A covered index at or above NUM_REGS gets no
// bit, so base+1 never wraps to register 0.
module sreg_span_decode #(
    parameter int NUM_REGS = 64,
    parameter int IDX_W    = 6
) (
    input  logic                vld,
    input  logic [IDX_W-1:0]    base,
    input  logic                wide,
    output logic [NUM_REGS-1:0] mask
);
    localparam int EXT_W = IDX_W + 1;

    logic [EXT_W-1:0] base_ext;
    logic [EXT_W-1:0] next_ext;

    // Extended indices so base+1 cannot overflow into a low register.
    assign base_ext = {1'b0, base};
    assign next_ext = base_ext + EXT_W'(1);

    // Per-register coverage test.
    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            mask[i] = vld && ((EXT_W'(i) == base_ext) ||
                              (wide && (EXT_W'(i) == next_ext)));
        end
    end
endmodule

// File: rtl/sreg_release_slot.sv
// Module: busy flag and release down-counter for one register.
// Priority at a clock edge: mark, then return arm, then arithmetic arm, then
// countdown. The counter value 1 means the flag clears at the next edge.
module sreg_release_slot #(
    parameter int PIPE_LEN = 6,
    parameter int TMR_W    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_busy,
    input  logic arm_ret,
    input  logic arm_alu,
    output logic busy,
    output logic pending
);
    logic [TMR_W-1:0] tmr;

    // Busy flag and release timer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            tmr  <= '0;
        end else if (set_busy) begin
            busy <= 1'b1;
            tmr  <= '0;
        end else if (arm_ret) begin
            tmr  <= TMR_W'(1);
        end else if (arm_alu) begin
            tmr  <= TMR_W'(PIPE_LEN);
        end else if (tmr == TMR_W'(1)) begin
            busy <= 1'b0;
            tmr  <= '0;
        end else if (tmr != '0) begin
            tmr  <= tmr - TMR_W'(1);
        end
    end

    assign pending = (tmr != '0);
endmodule

// File: rtl/sreg_stat_counters.sv
// Module: stall-cause and traffic counters. Assumes the increments are
// already qualified by the caller; counters wrap at 2**CNT_W.
module sreg_stat_counters #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_raw,
    input  logic             inc_wax,
    input  logic [2:0]       rd_add,
    input  logic [2:0]       wr_add,
    output logic [CNT_W-1:0] raw_stalls,
    output logic [CNT_W-1:0] wax_stalls,
    output logic [CNT_W-1:0] reg_reads,
    output logic [CNT_W-1:0] reg_writes
);
    // Accumulate all four counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_stalls <= '0;
            wax_stalls <= '0;
            reg_reads  <= '0;
            reg_writes <= '0;
        end else begin
            raw_stalls <= raw_stalls + CNT_W'(inc_raw);
            wax_stalls <= wax_stalls + CNT_W'(inc_wax);
            reg_reads  <= reg_reads + CNT_W'(rd_add);
            reg_writes <= reg_writes + CNT_W'(wr_add);
        end
    end
endmodule

// File: rtl/sreg_scoreboard.sv
// Module: top of the scalar register busy-bit scoreboard. Decodes six
// operands (two sources, query destination, mark, execute, return) into
// register masks, keeps one release slot per register, and drives the
// combinational issue decision and the statistics counters.
// Assumes PIPE_LEN >= 1 and at most one request per port per cycle.
module sreg_scoreboard
    import sreg_sb_pkg::*;
#(
    parameter int NUM_REGS = 64,
    parameter int PIPE_LEN = 6,
    parameter int CNT_W    = 32,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chk_valid,
    input  logic             chk_s0_vld,
    input  logic [IDX_W-1:0] chk_s0_base,
    input  logic             chk_s0_wide,
    input  logic             chk_s1_vld,
    input  logic [IDX_W-1:0] chk_s1_base,
    input  logic             chk_s1_wide,
    input  logic             chk_d_vld,
    input  logic [IDX_W-1:0] chk_d_base,
    input  logic             chk_d_wide,
    output logic             issue_ok,
    input  logic             mark_en,
    input  logic [IDX_W-1:0] mark_base,
    input  logic             mark_wide,
    input  logic             exec_en,
    input  logic [1:0]       exec_cls,
    input  logic [2:0]       exec_src_dw,
    input  logic             exec_d_vld,
    input  logic [IDX_W-1:0] exec_d_base,
    input  logic             exec_d_wide,
    input  logic             ret_en,
    input  logic [IDX_W-1:0] ret_base,
    input  logic             ret_wide,
    output logic [CNT_W-1:0] raw_stalls,
    output logic [CNT_W-1:0] wax_stalls,
    output logic [CNT_W-1:0] reg_reads,
    output logic [CNT_W-1:0] reg_writes
);
    localparam int NUM_OPS = 6;
    localparam int OP_S0   = 0;
    localparam int OP_S1   = 1;
    localparam int OP_DST  = 2;
    localparam int OP_MARK = 3;
    localparam int OP_EXEC = 4;
    localparam int OP_RET  = 5;
    localparam int TMR_W   = $clog2(PIPE_LEN + 1);

    logic                alu_exec;
    logic [NUM_OPS-1:0]  op_vld;
    logic [NUM_OPS-1:0]  op_wide;
    logic [IDX_W-1:0]    op_base [NUM_OPS];
    logic [NUM_REGS-1:0] op_mask [NUM_OPS];
    logic [NUM_REGS-1:0] busy;
    logic [NUM_REGS-1:0] pending;
    logic                src_hit;
    logic                dst_hit;
    logic [2:0]          rd_add;
    logic [2:0]          wr_add;

    // Only arithmetic results release through the execute port.
    assign alu_exec = exec_en && exec_d_vld && (exec_cls_e'(exec_cls) == CLS_ALU);

    // Gather the six operands into indexed form.
    always_comb begin
        op_vld[OP_S0]   = chk_s0_vld;
        op_base[OP_S0]  = chk_s0_base;
        op_wide[OP_S0]  = chk_s0_wide;
        op_vld[OP_S1]   = chk_s1_vld;
        op_base[OP_S1]  = chk_s1_base;
        op_wide[OP_S1]  = chk_s1_wide;
        op_vld[OP_DST]  = chk_d_vld;
        op_base[OP_DST] = chk_d_base;
        op_wide[OP_DST] = chk_d_wide;
        op_vld[OP_MARK] = mark_en;
        op_base[OP_MARK] = mark_base;
        op_wide[OP_MARK] = mark_wide;
        op_vld[OP_EXEC] = alu_exec;
        op_base[OP_EXEC] = exec_d_base;
        op_wide[OP_EXEC] = exec_d_wide;
        op_vld[OP_RET]  = ret_en;
        op_base[OP_RET] = ret_base;
        op_wide[OP_RET] = ret_wide;
    end

    generate
        for (genvar g = 0; g < NUM_OPS; g++) begin : g_dec
            sreg_span_decode #(
                .NUM_REGS (NUM_REGS),
                .IDX_W    (IDX_W)
            ) u_dec (
                .vld  (op_vld[g]),
                .base (op_base[g]),
                .wide (op_wide[g]),
                .mask (op_mask[g])
            );
        end

        for (genvar r = 0; r < NUM_REGS; r++) begin : g_slot
            sreg_release_slot #(
                .PIPE_LEN (PIPE_LEN),
                .TMR_W    (TMR_W)
            ) u_slot (
                .clk      (clk),
                .rst_n    (rst_n),
                .set_busy (op_mask[OP_MARK][r]),
                .arm_ret  (op_mask[OP_RET][r]),
                .arm_alu  (op_mask[OP_EXEC][r]),
                .busy     (busy[r]),
                .pending  (pending[r])
            );
        end
    endgenerate

    // Hazard decision: sources first, then destination.
    always_comb begin
        src_hit  = |(busy & (op_mask[OP_S0] | op_mask[OP_S1]));
        dst_hit  = |(busy & op_mask[OP_DST]);
        issue_ok = !src_hit && !dst_hit;
    end

    // Traffic increments for this cycle.
    always_comb begin
        rd_add = exec_en ? exec_src_dw : 3'd0;
        wr_add = (alu_exec ? {1'b0, span_dwords(exec_d_wide)} : 3'd0) +
                 (ret_en   ? {1'b0, span_dwords(ret_wide)}    : 3'd0);
    end

    sreg_stat_counters #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .inc_raw    (chk_valid && src_hit),
        .inc_wax    (chk_valid && !src_hit && dst_hit),
        .rd_add     (rd_add),
        .wr_add     (wr_add),
        .raw_stalls (raw_stalls),
        .wax_stalls (wax_stalls),
        .reg_reads  (reg_reads),
        .reg_writes (reg_writes)
    );
endmodule

// File: rtl/sreg_scoreboard_chk.sv
// Module: property checker for sreg_scoreboard, attached by bind below.
// Observes ports plus the per-register busy and pending vectors.
module sreg_scoreboard_chk #(
    parameter int NUM_REGS = 64,
    parameter int CNT_W    = 32,
    parameter int IDX_W    = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                chk_valid,
    input logic                issue_ok,
    input logic                mark_en,
    input logic [IDX_W-1:0]    mark_base,
    input logic                exec_en,
    input logic [1:0]          exec_cls,
    input logic [IDX_W-1:0]    exec_d_base,
    input logic                ret_en,
    input logic [IDX_W-1:0]    ret_base,
    input logic [CNT_W-1:0]    raw_stalls,
    input logic [CNT_W-1:0]    wax_stalls,
    input logic [CNT_W-1:0]    reg_reads,
    input logic [NUM_REGS-1:0] busy,
    input logic [NUM_REGS-1:0] pending
);
    // A refused valid query raises the two stall counts by one in total.
    p_one_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && !issue_ok) |=>
        ((raw_stalls - $past(raw_stalls)) + (wax_stalls - $past(wax_stalls))) == CNT_W'(1));

    // No count without a refused valid query.
    p_no_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!chk_valid || issue_ok) |=> ($stable(raw_stalls) && $stable(wax_stalls)));

    // A marked base register is busy after the edge.
    p_mark_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mark_en |=> busy[$past(mark_base)]);

    // A mark leaves no release pending on its base register.
    p_mark_cancels_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mark_en |=> !pending[$past(mark_base)]);

    // A non-arithmetic execute does not start a release.
    p_nonalu_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && (exec_cls != 2'd0) && !ret_en && !mark_en &&
         busy[exec_d_base] && !pending[exec_d_base]) |=>
        (busy[$past(exec_d_base)] && !pending[$past(exec_d_base)]));

    // A return frees its base register at the second edge.
    p_ret_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_en && !mark_en) ##1 (!mark_en && !exec_en && !ret_en) |=>
        !busy[$past(ret_base, 2)]);

    // Reads count only moves on an execute.
    p_reads_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_en |=> $stable(reg_reads));

    // With nothing busy, issue is always allowed.
    p_idle_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy == '0) |-> issue_ok);
endmodule

bind sreg_scoreboard sreg_scoreboard_chk #(
    .NUM_REGS (NUM_REGS),
    .CNT_W    (CNT_W),
    .IDX_W    (IDX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .chk_valid   (chk_valid),
    .issue_ok    (issue_ok),
    .mark_en     (mark_en),
    .mark_base   (mark_base),
    .exec_en     (exec_en),
    .exec_cls    (exec_cls),
    .exec_d_base (exec_d_base),
    .ret_en      (ret_en),
    .ret_base    (ret_base),
    .raw_stalls  (raw_stalls),
    .wax_stalls  (wax_stalls),
    .reg_reads   (reg_reads),
    .busy        (busy),
    .pending     (pending)
);

// File: tb/sreg_scoreboard_test.sv
// Bench: vector table of marks and issue queries, then directed tests for
// release timing, class handling, collisions, counters and reset.
module sreg_scoreboard_test;
    localparam int NR  = 16;
    localparam int PL  = 4;
    localparam int CW  = 16;
    localparam int IW  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          chk_valid = 0, chk_s0_vld = 0, chk_s0_wide = 0;
    logic          chk_s1_vld = 0, chk_s1_wide = 0, chk_d_vld = 0, chk_d_wide = 0;
    logic [IW-1:0] chk_s0_base = 0, chk_s1_base = 0, chk_d_base = 0;
    logic          issue_ok;
    logic          mark_en = 0, mark_wide = 0;
    logic [IW-1:0] mark_base = 0;
    logic          exec_en = 0, exec_d_vld = 0, exec_d_wide = 0;
    logic [1:0]    exec_cls = 0;
    logic [2:0]    exec_src_dw = 0;
    logic [IW-1:0] exec_d_base = 0;
    logic          ret_en = 0, ret_wide = 0;
    logic [IW-1:0] ret_base = 0;
    logic [CW-1:0] raw_stalls, wax_stalls, reg_reads, reg_writes;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_raw = 0, exp_wax = 0, exp_rd = 0, exp_wr = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sreg_scoreboard #(.NUM_REGS(NR), .PIPE_LEN(PL), .CNT_W(CW)) uut (.*);

    typedef struct packed {
        logic          mk;
        logic          qv;
        logic          s0v;
        logic [IW-1:0] s0b;
        logic          s0w;
        logic          s1v;
        logic [IW-1:0] s1b;
        logic          s1w;
        logic          dv;
        logic [IW-1:0] db;
        logic          dw;
        logic          ok;
        logic [1:0]    cause;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0, 1'b0,4'd0,1'b0,  1'b0,4'd0,1'b0,  1'b1,4'd3,1'b1,  1'b1,2'd0},
        '{1'b1,1'b0, 1'b0,4'd0,1'b0,  1'b0,4'd0,1'b0,  1'b1,4'd15,1'b1, 1'b1,2'd0},
        '{1'b1,1'b0, 1'b0,4'd0,1'b0,  1'b0,4'd0,1'b0,  1'b1,4'd8,1'b0,  1'b1,2'd0},
        '{1'b0,1'b1, 1'b1,4'd3,1'b0,  1'b0,4'd0,1'b0,  1'b0,4'd0,1'b0,  1'b0,2'd1},
        '{1'b0,1'b1, 1'b1,4'd2,1'b1,  1'b0,4'd0,1'b0,  1'b0,4'd0,1'b0,  1'b0,2'd1},
        '{1'b0,1'b1, 1'b1,4'd5,1'b0,  1'b1,4'd6,1'b0,  1'b1,4'd4,1'b0,  1'b0,2'd2},
        '{1'b0,1'b1, 1'b1,4'd4,1'b0,  1'b0,4'd0,1'b0,  1'b1,4'd8,1'b0,  1'b0,2'd1},
        '{1'b0,1'b1, 1'b1,4'd14,1'b1, 1'b0,4'd0,1'b0,  1'b0,4'd0,1'b0,  1'b0,2'd1},
        '{1'b0,1'b1, 1'b1,4'd0,1'b0,  1'b0,4'd0,1'b0,  1'b1,4'd14,1'b0, 1'b1,2'd0},
        '{1'b0,1'b1, 1'b0,4'd0,1'b0,  1'b0,4'd0,1'b0,  1'b1,4'd13,1'b1, 1'b1,2'd0},
        '{1'b0,1'b1, 1'b0,4'd0,1'b0,  1'b1,4'd8,1'b0,  1'b0,4'd0,1'b0,  1'b0,2'd1},
        '{1'b0,1'b1, 1'b0,4'd3,1'b0,  1'b0,4'd3,1'b0,  1'b0,4'd3,1'b0,  1'b1,2'd0},
        '{1'b0,1'b0, 1'b1,4'd3,1'b0,  1'b0,4'd0,1'b0,  1'b0,4'd0,1'b0,  1'b0,2'd0},
        '{1'b0,1'b1, 1'b1,4'd5,1'b1,  1'b0,4'd0,1'b0,  1'b1,4'd2,1'b1,  1'b0,2'd2},
        '{1'b0,1'b1, 1'b1,4'd1,1'b1,  1'b0,4'd0,1'b0,  1'b1,4'd0,1'b0,  1'b1,2'd0}
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic clr();
        chk_valid = 0; chk_s0_vld = 0; chk_s1_vld = 0; chk_d_vld = 0;
        chk_s0_wide = 0; chk_s1_wide = 0; chk_d_wide = 0;
        mark_en = 0; exec_en = 0; exec_d_vld = 0; ret_en = 0;
    endtask

    // Each request task drives at a falling edge and consumes one rising edge.
    task automatic do_mark(input int b, input bit w);
        mark_en = 1; mark_base = IW'(b); mark_wide = w;
        @(negedge clk); mark_en = 0;
    endtask

    task automatic do_exec(input int cls, input int b, input bit w, input int sdw);
        exec_en = 1; exec_cls = 2'(cls); exec_d_vld = 1; exec_d_base = IW'(b);
        exec_d_wide = w; exec_src_dw = 3'(sdw);
        exp_rd += sdw;
        if (cls == 0) exp_wr += (w ? 2 : 1);
        @(negedge clk); exec_en = 0; exec_d_vld = 0;
    endtask

    task automatic do_ret(input int b, input bit w);
        ret_en = 1; ret_base = IW'(b); ret_wide = w;
        exp_wr += (w ? 2 : 1);
        @(negedge clk); ret_en = 0;
    endtask

    // Query one register without counting; returns 1 when it is free.
    task automatic probe(input int b, output bit free);
        chk_valid = 0; chk_s1_vld = 0; chk_d_vld = 0;
        chk_s0_vld = 1; chk_s0_base = IW'(b); chk_s0_wide = 0;
        #1 free = issue_ok;
        chk_s0_vld = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_up();
    end

    initial begin
        bit f;
        clr();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R12: reset state
        probe(3, f);  check("R12 reset free", f, 1);
        check("R12 reset raw", raw_stalls, 0);
        check("R12 reset writes", reg_writes, 0);

        // Vector table walk (R1 R2 R3 R4)
        for (int i = 0; i < NV; i++) begin
            clr();
            if (VECS[i].mk) begin
                mark_en = 1; mark_base = VECS[i].db; mark_wide = VECS[i].dw;
            end else begin
                chk_valid = VECS[i].qv;
                chk_s0_vld = VECS[i].s0v; chk_s0_base = VECS[i].s0b; chk_s0_wide = VECS[i].s0w;
                chk_s1_vld = VECS[i].s1v; chk_s1_base = VECS[i].s1b; chk_s1_wide = VECS[i].s1w;
                chk_d_vld  = VECS[i].dv;  chk_d_base  = VECS[i].db;  chk_d_wide  = VECS[i].dw;
                #1;
                check(VECS[i].cause == 2'd1 ? "R1 vector" :
                      VECS[i].cause == 2'd2 ? "R2 vector" : "R4 vector",
                      issue_ok, VECS[i].ok);
                if (VECS[i].qv && VECS[i].cause == 2'd1) exp_raw++;
                if (VECS[i].qv && VECS[i].cause == 2'd2) exp_wax++;
            end
            @(negedge clk);
        end
        clr();
        #1;
        check("R3 raw count", raw_stalls, exp_raw);
        check("R3 wax count", wax_stalls, exp_wax);
        probe(0, f); check("R4 no wrap to 0", f, 1);

        // R5: arithmetic release timing
        do_mark(10, 0);
        do_exec(0, 10, 0, 3);
        probe(10, f); check("R5 busy after edge 0", f, 0);
        repeat (PL - 1) @(negedge clk);
        probe(10, f); check("R5 busy after edge PIPE_LEN-1", f, 0);
        @(negedge clk);
        probe(10, f); check("R5 free after edge PIPE_LEN", f, 1);

        // R6 and R7: load does not release, return does
        do_mark(11, 0);
        do_exec(1, 11, 0, 2);
        repeat (PL + 4) @(negedge clk);
        probe(11, f); check("R6 load held", f, 0);
        do_ret(11, 0);
        probe(11, f); check("R7 busy after return edge", f, 0);
        @(negedge clk);
        probe(11, f); check("R7 free one edge later", f, 1);

        // R11: mark collides with expiring return release
        do_mark(13, 0);
        do_ret(13, 0);
        do_mark(13, 0);
        probe(13, f); check("R11 mark wins", f, 0);
        repeat (3) @(negedge clk);
        probe(13, f); check("R11 still busy", f, 0);

        // R6: atomic does not release
        do_exec(2, 13, 0, 1);
        repeat (PL + 4) @(negedge clk);
        probe(13, f); check("R6 atomic held", f, 0);

        // R10: re-mark cancels pending arithmetic release
        do_mark(12, 1);
        do_exec(0, 12, 1, 4);
        @(negedge clk);
        do_mark(12, 1);
        repeat (PL + 2) @(negedge clk);
        probe(12, f); check("R10 cancel keeps busy", f, 0);

        #1;
        check("R8 reads count", reg_reads, exp_rd);
        check("R9 writes count", reg_writes, exp_wr);

        // R12: reset clears everything
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        probe(12, f); check("R12 reset frees busy", f, 1);
        probe(3, f);  check("R12 reset frees marked", f, 1);
        check("R12 reset clears reads", reg_reads, 0);
        check("R12 reset clears wax", wax_stalls, 0);
        finish_up();
    end
endmodule